// File: doc/BRIEF.md
# DMA Coherence Transaction Tracker

This block carries one DMA read or DMA write to a single coherent line from acceptance to completion. On acceptance it snoops every cache with a broadcast, shared for a read and exclusive for a write, issued on behalf of the directory itself. It then counts exactly one response per cache and records two flags: whether any responder still holds a shared copy, and whether any responder handed over dirty data. From that it picks cache data or memory data as the line's current value. A write has its bytes overlaid on that value and is pushed to memory. The DMA requestor receives the full line (read) or an acknowledge (write), and the block leaves the line in its new stable state.

The line has three stable states: NotOwner (`0`), Owner (`1`) and Exclusive (`2`). It resets to NotOwner. The controller states are IDLE, RD_ISSUE, RD_WAIT, RD_DONE, WR_ISSUE, WR_WAIT, WR_DONE and WR_MEM. The transitions are:
- IDLE→RD_ISSUE or IDLE→WR_ISSUE on an accepted request.
- RD_ISSUE→RD_WAIT and WR_ISSUE→WR_WAIT after one cycle.
- RD_WAIT→RD_DONE once the count is zero and no memory read is owed.
- WR_WAIT→WR_DONE once the count is zero.
- RD_DONE→IDLE and WR_DONE→WR_MEM after one cycle.
- WR_MEM→IDLE on the memory write acknowledge.

Top module: `dct_tracker`

## Requirements
- R1: After reset the line state is NotOwner (0). `busy`, `err` and every request, trigger and reply output are low.
- R2: A request with `dma_valid` high while idle is accepted in that cycle (`dma_accept`). In the next cycle `snp_valid` is high with `snp_addr` equal to the request address and `snp_excl` equal to `dma_write`.
- R3: The pending count loads NUM_CACHES on acceptance. It falls by exactly one for each response, whatever the value of `rsp_acks`, and completion needs exactly NUM_CACHES responses.
- R4: Response kinds are 0 ack, 1 shared ack, 2 shared data and 3 exclusive data. Kinds 1 and 2 set the sharer flag. Kinds 2 and 3 set the dirty flag and capture `rsp_data` as the line value.
- R5: Two cycles after the last owed response or memory beat, `trig_valid` pulses for one cycle. `trig_shared` equals the sharer flag.
- R6: For a read that started in NotOwner or Exclusive, the reply carries the full line in the trigger cycle (`dma_rsp_ack`=0). The line then becomes Owner if the sharer flag is set and Exclusive otherwise.
- R7: A read that starts in NotOwner issues no memory read. If it completes with neither sharer nor dirty flag set, `err` rises.
- R8: A read that starts in Owner or Exclusive pulses `mem_rd_req` in the cycle after acceptance. For an Owner start, the memory data is forwarded to the DMA requestor in the same cycle it arrives, no reply follows at completion, and the line returns to Owner.
- R9: In the trigger cycle, a write pulses `mem_wr_req`. Bytes from `dma_off` to `dma_off+dma_len-1` come from `dma_wdata`, and the other bytes keep the current line value (byte b is bits 8b+7:8b). `mem_wr_be` is all ones if dirty data was supplied, otherwise only the window. On `mem_wr_ack` an acknowledge reply goes out in that cycle and the line becomes Exclusive.
- R10: A request that arrives while busy is not accepted and `dma_recycle` is high in that cycle.
- R11: A response that arrives while idle, or when the count is already zero, sets the sticky `err` flag.
- R12: Memory read data is stored as the line value only if no dirty cache data has been captured, including in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dma_valid | input | 1 | DMA request present |
| dma_write | input | 1 | 1 write, 0 read |
| dma_addr | input | ADDR_W | Line address |
| dma_off | input | OFF_W | First byte of the write window |
| dma_len | input | LEN_W | Bytes in the write window |
| dma_wdata | input | DW | Write bytes, line aligned |
| dma_src | input | SRC_W | Requestor id |
| dma_accept | output | 1 | Request taken this cycle |
| dma_recycle | output | 1 | Request refused, retry later |
| snp_valid | output | 1 | Broadcast snoop |
| snp_excl | output | 1 | Snoop is exclusive (1) or shared (0) |
| snp_addr | output | ADDR_W | Snoop address |
| rsp_valid | input | 1 | Cache response present |
| rsp_kind | input | 2 | Response kind |
| rsp_acks | input | 2 | Carried ack count, ignored |
| rsp_data | input | DW | Cache data |
| mem_rd_req | output | 1 | Memory read request |
| mem_wr_req | output | 1 | Memory write request |
| mem_addr | output | ADDR_W | Memory address |
| mem_wr_data | output | DW | Merged write line |
| mem_wr_be | output | LINE_BYTES | Write byte enables |
| mem_rd_valid | input | 1 | Memory read data present |
| mem_rd_data | input | DW | Memory read data |
| mem_wr_ack | input | 1 | Memory write done |
| trig_valid | output | 1 | All responses collected |
| trig_shared | output | 1 | Sharer flag at completion |
| dma_rsp_valid | output | 1 | Reply to DMA requestor |
| dma_rsp_ack | output | 1 | Reply is a write acknowledge |
| dma_rsp_data | output | DW | Reply line data |
| dma_rsp_dst | output | SRC_W | Reply destination |
| line_state | output | 2 | Stable line state |
| busy | output | 1 | Transaction active |
| err | output | 1 | Sticky protocol error |

## Verification
Acceptance, refusal, Owner-start data forwarding and the write acknowledge are combinational and due in the same cycle as their stimulus, so the bench samples them one time step after driving. The snoop and memory read request are due one edge after acceptance. The trigger, the completion reply and the memory write are due at the second edge after the last owed response or memory beat, with the trigger confirmed low after the first. Line state and the error flag are registered and are sampled at the falling edge after the edge that updates them. The write merge is swept over every offset and length of an eight-byte line, with and without dirty cache data, against bytes computed in the bench.

// File: rtl/dct_pkg.sv
package dct_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_RD_ISSUE,
        S_RD_WAIT,
        S_RD_DONE,
        S_WR_ISSUE,
        S_WR_WAIT,
        S_WR_DONE,
        S_WR_MEM
    } dct_st_e;

    typedef enum logic [1:0] {
        LN_NO = 2'd0,
        LN_OW = 2'd1,
        LN_EX = 2'd2
    } dct_line_e;

    localparam logic [1:0] RK_ACK   = 2'd0;
    localparam logic [1:0] RK_SACK  = 2'd1;
    localparam logic [1:0] RK_SDATA = 2'd2;
    localparam logic [1:0] RK_XDATA = 2'd3;
endpackage

// File: rtl/dct_pend.sv
module dct_pend #(
    parameter int NUM = 4,
    localparam int CW = $clog2(NUM + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          dec,
    output logic [CW-1:0] cnt,
    output logic          zero
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= CW'(NUM);
        end else if (dec && cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign zero = (cnt == '0);

    AST_PEND_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(NUM));  // R3
    AST_ONE_PER_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        (dec && !load && !zero) |=> (cnt == CW'($past(cnt) - 1'b1)));  // R3
endmodule

// File: rtl/dct_merge.sv
module dct_merge #(
    parameter int LINE_BYTES = 8,
    localparam int DW    = LINE_BYTES * 8,
    localparam int OFF_W = $clog2(LINE_BYTES),
    localparam int LEN_W = $clog2(LINE_BYTES + 1)
) (
    input  logic [DW-1:0]         base,
    input  logic [DW-1:0]         wdata,
    input  logic [OFF_W-1:0]      off,
    input  logic [LEN_W-1:0]      len,
    output logic [DW-1:0]         merged,
    output logic [LINE_BYTES-1:0] win
);
    localparam int SW = LEN_W + 1;
    logic [SW-1:0] stop;
    assign stop = SW'(off) + SW'(len);

    for (genvar b = 0; b < LINE_BYTES; b++) begin : g_byte
        assign win[b] = (SW'(b) >= SW'(off)) && (SW'(b) < stop);
        assign merged[8*b +: 8] = win[b] ? wdata[8*b +: 8] : base[8*b +: 8];
    end
endmodule

// File: rtl/dct_tracker.sv
module dct_tracker
    import dct_pkg::*;
#(
    parameter int NUM_CACHES = 4,
    parameter int LINE_BYTES = 8,
    parameter int ADDR_W     = 16,
    parameter int SRC_W      = 4,
    localparam int DW    = LINE_BYTES * 8,
    localparam int OFF_W = $clog2(LINE_BYTES),
    localparam int LEN_W = $clog2(LINE_BYTES + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  dma_valid,
    input  logic                  dma_write,
    input  logic [ADDR_W-1:0]     dma_addr,
    input  logic [OFF_W-1:0]      dma_off,
    input  logic [LEN_W-1:0]      dma_len,
    input  logic [DW-1:0]         dma_wdata,
    input  logic [SRC_W-1:0]      dma_src,
    output logic                  dma_accept,
    output logic                  dma_recycle,
    output logic                  snp_valid,
    output logic                  snp_excl,
    output logic [ADDR_W-1:0]     snp_addr,
    input  logic                  rsp_valid,
    input  logic [1:0]            rsp_kind,
    input  logic [1:0]            rsp_acks,
    input  logic [DW-1:0]         rsp_data,
    output logic                  mem_rd_req,
    output logic                  mem_wr_req,
    output logic [ADDR_W-1:0]     mem_addr,
    output logic [DW-1:0]         mem_wr_data,
    output logic [LINE_BYTES-1:0] mem_wr_be,
    input  logic                  mem_rd_valid,
    input  logic [DW-1:0]         mem_rd_data,
    input  logic                  mem_wr_ack,
    output logic                  trig_valid,
    output logic                  trig_shared,
    output logic                  dma_rsp_valid,
    output logic                  dma_rsp_ack,
    output logic [DW-1:0]         dma_rsp_data,
    output logic [SRC_W-1:0]      dma_rsp_dst,
    output logic [1:0]            line_state,
    output logic                  busy,
    output logic                  err
);
    localparam int CW = $clog2(NUM_CACHES + 1);

    dct_st_e               st, st_nx;
    dct_line_e             line_q;
    logic [ADDR_W-1:0]     addr_q;
    logic [OFF_W-1:0]      off_q;
    logic [LEN_W-1:0]      len_q;
    logic [DW-1:0]         wdata_q;
    logic [DW-1:0]         buf_q;
    logic [SRC_W-1:0]      src_q;
    logic                  sharer_q, dirty_q, mem_pend_q, from_owner_q, start_no_q, err_q;
    logic [CW-1:0]         pend_cnt;
    logic                  pend_zero;
    logic                  accept, counting, rd_phase;
    logic                  rsp_take, rsp_bad, rsp_shares, rsp_dirty, mem_take;
    logic [DW-1:0]         merged;
    logic [LINE_BYTES-1:0] win;

    // rsp_acks is deliberately not used: every response counts as one
    logic unused_acks;
    assign unused_acks = ^rsp_acks;

    assign accept     = (st == S_IDLE) && dma_valid;
    assign counting   = (st == S_RD_ISSUE) || (st == S_RD_WAIT) ||
                        (st == S_WR_ISSUE) || (st == S_WR_WAIT);
    assign rd_phase   = (st == S_RD_ISSUE) || (st == S_RD_WAIT);
    assign rsp_take   = rsp_valid && counting && !pend_zero;
    assign rsp_bad    = rsp_valid && !rsp_take;
    assign rsp_shares = (rsp_kind == RK_SACK) || (rsp_kind == RK_SDATA);
    assign rsp_dirty  = (rsp_kind == RK_SDATA) || (rsp_kind == RK_XDATA);
    assign mem_take   = rd_phase && mem_pend_q && mem_rd_valid;

    dct_pend #(.NUM(NUM_CACHES)) u_pend (
        .clk  (clk),
        .rst_n(rst_n),
        .load (accept),
        .dec  (rsp_take),
        .cnt  (pend_cnt),
        .zero (pend_zero)
    );

    dct_merge #(.LINE_BYTES(LINE_BYTES)) u_merge (
        .base  (buf_q),
        .wdata (wdata_q),
        .off   (off_q),
        .len   (len_q),
        .merged(merged),
        .win   (win)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st <= S_IDLE;
        else        st <= st_nx;
    end

    always_comb begin
        st_nx = st;
        unique case (st)
            S_IDLE:     if (dma_valid) st_nx = dma_write ? S_WR_ISSUE : S_RD_ISSUE;
            S_RD_ISSUE: st_nx = S_RD_WAIT;
            S_RD_WAIT:  if (pend_zero && !mem_pend_q) st_nx = S_RD_DONE;
            S_RD_DONE:  st_nx = S_IDLE;
            S_WR_ISSUE: st_nx = S_WR_WAIT;
            S_WR_WAIT:  if (pend_zero) st_nx = S_WR_DONE;
            S_WR_DONE:  st_nx = S_WR_MEM;
            S_WR_MEM:   if (mem_wr_ack) st_nx = S_IDLE;
            default:    st_nx = S_IDLE;
        endcase
    end

    // transaction record, flags and line state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_q       <= LN_NO;
            addr_q       <= '0;
            off_q        <= '0;
            len_q        <= '0;
            wdata_q      <= '0;
            buf_q        <= '0;
            src_q        <= '0;
            sharer_q     <= 1'b0;
            dirty_q      <= 1'b0;
            mem_pend_q   <= 1'b0;
            from_owner_q <= 1'b0;
            start_no_q   <= 1'b0;
            err_q        <= 1'b0;
        end else begin
            if (accept) begin
                addr_q       <= dma_addr;
                off_q        <= dma_off;
                len_q        <= dma_len;
                wdata_q      <= dma_wdata;
                src_q        <= dma_src;
                buf_q        <= '0;
                sharer_q     <= 1'b0;
                dirty_q      <= 1'b0;
                mem_pend_q   <= !dma_write && (line_q != LN_NO);
                from_owner_q <= !dma_write && (line_q == LN_OW);
                start_no_q   <= (line_q == LN_NO);
            end
            if (mem_take) begin
                mem_pend_q <= 1'b0;
                if (!dirty_q && !(rsp_take && rsp_dirty)) buf_q <= mem_rd_data;
            end
            if (rsp_take) begin
                if (rsp_shares) sharer_q <= 1'b1;
                if (rsp_dirty) begin
                    dirty_q <= 1'b1;
                    buf_q   <= rsp_data;
                end
            end
            if (st == S_RD_DONE) begin
                if (from_owner_q || sharer_q) line_q <= LN_OW;
                else                          line_q <= LN_EX;
                if (start_no_q && !sharer_q && !dirty_q) err_q <= 1'b1;
            end
            if (st == S_WR_MEM && mem_wr_ack) line_q <= LN_EX;
            if (rsp_bad) err_q <= 1'b1;
        end
    end

    // outputs
    always_comb begin
        dma_accept    = accept;
        dma_recycle   = dma_valid && (st != S_IDLE);
        snp_valid     = (st == S_RD_ISSUE) || (st == S_WR_ISSUE);
        snp_excl      = (st == S_WR_ISSUE);
        snp_addr      = addr_q;
        mem_rd_req    = (st == S_RD_ISSUE) && mem_pend_q;
        mem_wr_req    = (st == S_WR_DONE);
        mem_addr      = addr_q;
        mem_wr_data   = merged;
        mem_wr_be     = dirty_q ? {LINE_BYTES{1'b1}} : win;
        trig_valid    = (st == S_RD_DONE) || (st == S_WR_DONE);
        trig_shared   = sharer_q;
        dma_rsp_valid = 1'b0;
        dma_rsp_ack   = 1'b0;
        dma_rsp_data  = '0;
        dma_rsp_dst   = src_q;
        if (mem_take && from_owner_q) begin
            dma_rsp_valid = 1'b1;
            dma_rsp_data  = mem_rd_data;
        end else if (st == S_RD_DONE && !from_owner_q) begin
            dma_rsp_valid = 1'b1;
            dma_rsp_data  = buf_q;
        end else if (st == S_WR_MEM && mem_wr_ack) begin
            dma_rsp_valid = 1'b1;
            dma_rsp_ack   = 1'b1;
        end
        line_state = line_q;
        busy       = (st != S_IDLE);
        err        = err_q;
    end

    AST_TRIG_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        trig_valid |-> pend_zero);  // R5
    AST_BUSY_REFUSES: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_valid && busy) |-> (dma_recycle && !dma_accept));  // R10
    AST_WR_ENDS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_rsp_valid && dma_rsp_ack) |=> (line_state == LN_EX));  // R9
    AST_NO_FETCH_FROM_NO: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_accept && !dma_write && line_state == LN_NO) |=> !mem_rd_req);  // R7
endmodule

// File: tb/dct_tracker_tb.sv
module dct_tracker_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        dma_valid = 0, dma_write = 0;
    logic [15:0] dma_addr = '0;
    logic [2:0]  dma_off = '0;
    logic [3:0]  dma_len = '0;
    logic [63:0] dma_wdata = '0;
    logic [3:0]  dma_src = '0;
    logic        dma_accept, dma_recycle, snp_valid, snp_excl;
    logic [15:0] snp_addr, mem_addr;
    logic        rsp_valid = 0;
    logic [1:0]  rsp_kind = '0, rsp_acks = '0;
    logic [63:0] rsp_data = '0;
    logic        mem_rd_req, mem_wr_req;
    logic [63:0] mem_wr_data;
    logic [7:0]  mem_wr_be;
    logic        mem_rd_valid = 0, mem_wr_ack = 0;
    logic [63:0] mem_rd_data = '0;
    logic        trig_valid, trig_shared, dma_rsp_valid, dma_rsp_ack;
    logic [63:0] dma_rsp_data;
    logic [3:0]  dma_rsp_dst;
    logic [1:0]  line_state;
    logic        busy, err;

    int total = 0, bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    dct_tracker u_dut (
        .clk(clk), .rst_n(rst_n),
        .dma_valid(dma_valid), .dma_write(dma_write), .dma_addr(dma_addr),
        .dma_off(dma_off), .dma_len(dma_len), .dma_wdata(dma_wdata), .dma_src(dma_src),
        .dma_accept(dma_accept), .dma_recycle(dma_recycle),
        .snp_valid(snp_valid), .snp_excl(snp_excl), .snp_addr(snp_addr),
        .rsp_valid(rsp_valid), .rsp_kind(rsp_kind), .rsp_acks(rsp_acks), .rsp_data(rsp_data),
        .mem_rd_req(mem_rd_req), .mem_wr_req(mem_wr_req), .mem_addr(mem_addr),
        .mem_wr_data(mem_wr_data), .mem_wr_be(mem_wr_be),
        .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data), .mem_wr_ack(mem_wr_ack),
        .trig_valid(trig_valid), .trig_shared(trig_shared),
        .dma_rsp_valid(dma_rsp_valid), .dma_rsp_ack(dma_rsp_ack),
        .dma_rsp_data(dma_rsp_data), .dma_rsp_dst(dma_rsp_dst),
        .line_state(line_state), .busy(busy), .err(err)
    );

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
    endtask

    task automatic start_txn(bit wr, int off, int len, logic [63:0] wd, bit fetch);
        @(negedge clk);
        dma_valid = 1; dma_write = wr; dma_addr = 16'h0140;
        dma_off = 3'(off); dma_len = 4'(len); dma_wdata = wd; dma_src = 4'h9;
        #1 check("R2 accept", dma_accept, 1);
        @(posedge clk); #1 dma_valid = 0;
        @(negedge clk);
        check("R2 snoop", snp_valid, 1);
        check("R2 excl", snp_excl, wr);
        check("R2 addr", snp_addr, 16'h0140);
        if (fetch) check("R8 fetch", mem_rd_req, 1);
        else       check("R7 no fetch", mem_rd_req, 0);
        @(posedge clk); #1;
    endtask

    task automatic send_rsp(logic [1:0] kind, logic [1:0] acks, logic [63:0] d);
        @(negedge clk);
        rsp_valid = 1; rsp_kind = kind; rsp_acks = acks; rsp_data = d;
        @(posedge clk); #1 rsp_valid = 0;
    endtask

    task automatic send_mem(logic [63:0] d, bit fwd);
        @(negedge clk);
        mem_rd_valid = 1; mem_rd_data = d;
        #1 check("R8 forward", dma_rsp_valid, fwd);
        if (fwd) check("R8 forward data", dma_rsp_data, d);
        @(posedge clk); #1 mem_rd_valid = 0;
    endtask

    task automatic finish_rd(bit shr, bit reply, logic [63:0] d, logic [1:0] ln);
        @(negedge clk);
        check("R5 no early trigger", trig_valid, 0);
        @(posedge clk); @(negedge clk);
        check("R5 trigger", trig_valid, 1);
        check("R5 shared", trig_shared, shr);
        check("R6 reply", dma_rsp_valid, reply);
        if (reply) begin
            check("R6 data", dma_rsp_data, d);
            check("R6 ack bit", dma_rsp_ack, 0);
            check("R6 dest", dma_rsp_dst, 4'h9);
        end
        @(posedge clk); @(negedge clk);
        check("R6 final state", line_state, ln);
        check("R6 idle", busy, 0);
    endtask

    task automatic finish_wr(logic [63:0] d, logic [7:0] be);
        @(negedge clk);
        check("R5 no early trigger", trig_valid, 0);
        @(posedge clk); @(negedge clk);
        check("R5 trigger", trig_valid, 1);
        check("R5 shared", trig_shared, 0);
        check("R9 mem write", mem_wr_req, 1);
        check("R9 merged", mem_wr_data, d);
        check("R9 byte enables", mem_wr_be, be);
        @(posedge clk); @(negedge clk);
        check("R9 single write", mem_wr_req, 0);
        mem_wr_ack = 1;
        #1 check("R9 ack reply", {dma_rsp_valid, dma_rsp_ack}, 2'b11);
        @(posedge clk); #1 mem_wr_ack = 0;
        @(negedge clk);
        check("R9 exclusive", line_state, 2);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        do_reset();
        @(negedge clk);
        check("R1 line", line_state, 0);
        check("R1 busy", busy, 0);
        check("R1 err", err, 0);
        check("R1 outputs", {snp_valid, mem_rd_req, mem_wr_req, trig_valid, dma_rsp_valid}, 0);

        // NotOwner read, sharers present, dirty data from a sharer -> Owner
        start_txn(0, 0, 0, 64'h0, 0);
        send_rsp(0, 1, 64'h0);
        @(negedge clk);
        dma_valid = 1; dma_write = 1;
        #1 check("R10 recycle", dma_recycle, 1);
        check("R10 not accepted", dma_accept, 0);
        @(posedge clk); #1 dma_valid = 0;
        send_rsp(1, 2, 64'h0);                      // R4 shared ack, ack count 2 ignored
        send_rsp(2, 2, 64'hD1D2D3D4D5D6D7D8);       // R4 shared data
        @(negedge clk);
        check("R3 not done after 3", trig_valid, 0);
        send_rsp(0, 1, 64'h0);
        finish_rd(1, 1, 64'hD1D2D3D4D5D6D7D8, 1);

        // Owner read: memory data forwarded at once, returns to Owner
        start_txn(0, 0, 0, 64'h0, 1);
        send_rsp(0, 1, 64'h0);
        send_mem(64'h0123456789ABCDEF, 1);
        for (int i = 0; i < 3; i++) send_rsp(0, 1, 64'h0);
        finish_rd(0, 0, 64'h0, 1);

        // write sweep over every window, clean and dirty base
        for (int dirty = 0; dirty < 2; dirty++) begin
            for (int off = 0; off < 8; off++) begin
                for (int len = 1; len <= 8 - off; len++) begin
                    logic [63:0] wd, cd, ed;
                    logic [7:0]  be;
                    wd = 64'hA0A1A2A3A4A5A6A7 ^ {8{8'(off * 16 + len)}};
                    cd = 64'h1122334455667788 + 64'(off);
                    ed = '0; be = '0;
                    for (int b = 0; b < 8; b++) begin
                        if (b >= off && b < off + len) begin
                            ed[8*b +: 8] = wd[8*b +: 8];
                            be[b] = 1'b1;
                        end else if (dirty != 0) begin
                            ed[8*b +: 8] = cd[8*b +: 8];
                        end
                    end
                    if (dirty != 0) be = 8'hFF;
                    start_txn(1, off, len, wd, 0);
                    send_rsp(dirty != 0 ? 2'd3 : 2'd0, 2, cd);
                    for (int i = 0; i < 3; i++) send_rsp(0, 1, 64'h0);
                    finish_wr(ed, be);
                end
            end
        end

        // Exclusive read: dirty cache data beats later memory data (R12)
        start_txn(0, 0, 0, 64'h0, 1);
        send_rsp(3, 2, 64'hCAFEF00D12345678);
        send_mem(64'h5555AAAA5555AAAA, 0);
        for (int i = 0; i < 3; i++) send_rsp(0, 1, 64'h0);
        finish_rd(0, 1, 64'hCAFEF00D12345678, 2);

        // Exclusive read with a sharer -> Owner, memory data returned
        start_txn(0, 0, 0, 64'h0, 1);
        send_mem(64'h7766554433221100, 0);
        send_rsp(1, 2, 64'h0);
        for (int i = 0; i < 3; i++) send_rsp(0, 1, 64'h0);
        finish_rd(1, 1, 64'h7766554433221100, 1);
        check("R11 no error so far", err, 0);

        // NotOwner read with no sharer and no dirty data -> error
        do_reset();
        start_txn(0, 0, 0, 64'h0, 0);
        for (int i = 0; i < 4; i++) send_rsp(0, 1, 64'h0);
        finish_rd(0, 1, 64'h0, 2);
        check("R7 missing dirty data", err, 1);

        // stray response while idle
        do_reset();
        @(negedge clk);
        check("R11 clear after reset", err, 0);
        send_rsp(0, 1, 64'h0);
        @(negedge clk);
        check("R11 stray response", err, 1);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule